// File: doc/BRIEF.md
# Channel-Status Block Timer and Bit Presenter

This block sits behind a digital-audio frame decoder. It receives one strobe for each decoded frame, a flag that marks the frame opening a new channel-status block, and that frame's channel-status bit and user bit. From these it produces three things. The first is a word clock at the frame rate. The second is the two per-frame bits, changed only on that clock's rising edges. The third is a block indicator that rises a fixed number of frames after the block-start frame and stays high for a fixed number of frames.

The word clock comes from one of two sources. When the serial output port is the clock master (`lrck_master` = 1), the port's own left/right clock, `lrck_in`, is the word clock. When the port is a slave, the block makes the clock itself. It measures the frame period in system clocks and drives the clock high for the first half of each frame.

The block indicator is a state machine with four states. BS_IDLE means no block start has been seen since reset. BS_WAIT counts frames after a block start. BS_ON drives the indicator high. BS_DONE means the pulse is finished. The transitions are:
- BS_IDLE→BS_WAIT on a block-start strobe.
- BS_WAIT→BS_ON on the second frame after the start.
- BS_ON→BS_DONE after sixteen frames.
- Any state→BS_WAIT on a block-start strobe.

Top module: `cu_block_timer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `blk_ind`, `c_out` and `u_out` are 0. In slave mode `wclk_out` is also 0.
- R2: Until the first strobe with `z_flag` = 1 after reset, `c_out`, `u_out` and `blk_ind` stay 0, whatever strobes and bits arrive.
- R3: In slave mode (`lrck_master` = 0), `wclk_out` is 1 in the cycle after every strobe. The strobe-to-strobe distance ending at a strobe is P cycles. After that strobe, `wclk_out` falls once floor(P/2) cycles have passed, giving a 50% duty cycle for even P.
- R4: In master mode (`lrck_master` = 1), `wclk_out` equals `lrck_in` in every cycle.
- R5: `c_out` and `u_out` change only in the cycle after a cycle in which `wclk_out` was 1 and had been 0 one cycle earlier. At such a change they load the `c_in`/`u_in` values taken at the most recent strobe.
- R6: `blk_ind` rises in the cycle after the second strobe that follows a block-start strobe (frame index 2, counting the start frame as 0).
- R7: `blk_ind` stays high for exactly 16 frame strobes and then stays low until the next block-start strobe. It changes only in the cycle after a strobe.
- R8: A block-start strobe restarts the count from any state, including while `blk_ind` is high. `blk_ind` is 0 in the cycle after that strobe, and R6 and R7 then apply again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_stb | input | 1 | One-cycle pulse per decoded frame |
| z_flag | input | 1 | Frame is a block start; valid with `frame_stb` |
| c_in | input | 1 | Channel-status bit of the frame; valid with `frame_stb` |
| u_in | input | 1 | User bit of the frame; valid with `frame_stb` |
| lrck_master | input | 1 | 1: serial port is master, use `lrck_in`; 0: generate the clock |
| lrck_in | input | 1 | Left/right clock of the serial port in master mode |
| wclk_out | output | 1 | Frame-rate word clock |
| c_out | output | 1 | Channel-status bit output |
| u_out | output | 1 | User bit output |
| blk_ind | output | 1 | Block indicator pulse |

## Verification
Strobes sent before any block start show whether the output gating waits for lock or opens on any frame. Even and odd frame periods, and a change of period mid-run, show whether the generated clock follows the measured period or a fixed one. A block start that arrives while the indicator is high shows whether the count restarts or is ignored. Master-mode frames use a left/right clock placed out of phase with the strobes, which shows whether the bit outputs follow the word clock's edges or the strobe.

// File: rtl/cu_pkg.sv
package cu_pkg;
    typedef enum logic [1:0] {
        BS_IDLE = 2'd0,
        BS_WAIT = 2'd1,
        BS_ON   = 2'd2,
        BS_DONE = 2'd3
    } blk_state_t;
endpackage

// File: rtl/cu_wclk_gen.sv
module cu_wclk_gen #(
    parameter int PW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    output logic wclk_int
);
    localparam logic [PW-1:0] PH_MAX = {PW{1'b1}};

    logic [PW-1:0] phase;
    logic [PW-1:0] period;
    logic [PW-1:0] half;

    assign half = period >> 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            period   <= '0;
            wclk_int <= 1'b0;
        end else if (frame_stb) begin
            period   <= phase;
            phase    <= PW'(1);
            wclk_int <= 1'b1;
        end else begin
            if (phase != PH_MAX) phase <= phase + PW'(1);
            if (phase == half) wclk_int <= 1'b0;
        end
    end

    assert_wclk_high_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && $past(rst_n)) |=> wclk_int);
endmodule

// File: rtl/cu_blk_fsm.sv
module cu_blk_fsm
    import cu_pkg::*;
#(
    parameter int DLY = 2,
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic z_flag,
    output logic blk_ind,
    output logic locked
);
    localparam int FMAX = (DLY > LEN) ? DLY : LEN;
    localparam int FW   = $clog2(FMAX + 1);
    localparam logic [FW-1:0] DLY_LAST = FW'(DLY - 1);
    localparam logic [FW-1:0] LEN_LAST = FW'(LEN - 1);

    blk_state_t st, st_n;
    logic [FW-1:0] fcnt, fcnt_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= BS_IDLE;
            fcnt <= '0;
        end else begin
            st   <= st_n;
            fcnt <= fcnt_n;
        end
    end

    always_comb begin
        st_n   = st;
        fcnt_n = fcnt;
        if (frame_stb) begin
            if (z_flag) begin
                st_n   = BS_WAIT;
                fcnt_n = '0;
            end else begin
                unique case (st)
                    BS_IDLE: st_n = BS_IDLE;
                    BS_WAIT: begin
                        if (fcnt == DLY_LAST) begin
                            st_n   = BS_ON;
                            fcnt_n = '0;
                        end else begin
                            fcnt_n = fcnt + FW'(1);
                        end
                    end
                    BS_ON: begin
                        if (fcnt == LEN_LAST) begin
                            st_n   = BS_DONE;
                            fcnt_n = '0;
                        end else begin
                            fcnt_n = fcnt + FW'(1);
                        end
                    end
                    BS_DONE: st_n = BS_DONE;
                endcase
            end
        end
    end

    always_comb begin
        blk_ind = (st == BS_ON);
        locked  = (st != BS_IDLE);
    end

    assert_blk_rise_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(blk_ind) && $past(rst_n)) |-> $past(frame_stb));
    assert_blk_steady_between_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_stb && $past(rst_n)) |=> $stable(blk_ind));
    assert_z_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_stb && z_flag) |=> !blk_ind);
endmodule

// File: rtl/cu_bit_out.sv
module cu_bit_out (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic c_in,
    input  logic u_in,
    input  logic wclk,
    input  logic locked,
    output logic c_out,
    output logic u_out
);
    logic wclk_d;
    logic hold_c;
    logic hold_u;
    logic wrise;

    assign wrise = wclk && !wclk_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_d <= 1'b0;
            hold_c <= 1'b0;
            hold_u <= 1'b0;
            c_out  <= 1'b0;
            u_out  <= 1'b0;
        end else begin
            wclk_d <= wclk;
            if (frame_stb) begin
                hold_c <= c_in;
                hold_u <= u_in;
            end
            if (wrise && locked) begin
                c_out <= hold_c;
                u_out <= hold_u;
            end
        end
    end

    assert_cu_only_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (c_out != $past(c_out) || u_out != $past(u_out))) |-> $past(wrise));
    assert_cu_zero_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> (!c_out && !u_out));
endmodule

// File: rtl/cu_block_timer.sv
module cu_block_timer #(
    parameter int PW  = 16,
    parameter int DLY = 2,
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_stb,
    input  logic z_flag,
    input  logic c_in,
    input  logic u_in,
    input  logic lrck_master,
    input  logic lrck_in,
    output logic wclk_out,
    output logic c_out,
    output logic u_out,
    output logic blk_ind
);
    logic wclk_int;
    logic locked;

    cu_wclk_gen #(.PW(PW)) u_wclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .wclk_int (wclk_int)
    );

    cu_blk_fsm #(.DLY(DLY), .LEN(LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .z_flag   (z_flag),
        .blk_ind  (blk_ind),
        .locked   (locked)
    );

    assign wclk_out = lrck_master ? lrck_in : wclk_int;

    cu_bit_out u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_stb(frame_stb),
        .c_in     (c_in),
        .u_in     (u_in),
        .wclk     (wclk_out),
        .locked   (locked),
        .c_out    (c_out),
        .u_out    (u_out)
    );

    assert_master_follows_lrck_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lrck_master |-> (wclk_out == lrck_in));
endmodule

// File: tb/cu_block_timer_test.sv
module cu_block_timer_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_stb = 1'b0;
    logic z_flag = 1'b0;
    logic c_in = 1'b0;
    logic u_in = 1'b0;
    logic lrck_master = 1'b0;
    logic lrck_in = 1'b0;
    logic wclk_out, c_out, u_out, blk_ind;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] lf = 16'hACE1;

    cu_block_timer uut (
        .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .z_flag(z_flag),
        .c_in(c_in), .u_in(u_in), .lrck_master(lrck_master), .lrck_in(lrck_in),
        .wclk_out(wclk_out), .c_out(c_out), .u_out(u_out), .blk_ind(blk_ind)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: frames since block start, cycles since strobe
    int m_ph = 0, m_per = 0, m_fr = -1;
    bit m_w = 0, m_wp = 0, m_hc = 0, m_hu = 0, m_c = 0, m_u = 0;

    always @(posedge clk) begin
        bit ws;
        if (!rst_n) begin
            m_ph = 0; m_per = 0; m_fr = -1;
            m_w = 0; m_wp = 0; m_hc = 0; m_hu = 0; m_c = 0; m_u = 0;
        end else begin
            ws = lrck_master ? lrck_in : m_w;
            if (ws && !m_wp && m_fr >= 0) begin m_c = m_hc; m_u = m_hu; end
            m_wp = ws;
            if (frame_stb) begin
                m_hc = c_in; m_hu = u_in;
                m_per = m_ph; m_ph = 1; m_w = 1;
                if (z_flag) m_fr = 0;
                else if (m_fr >= 0 && m_fr < 100000) m_fr++;
            end else begin
                if (m_ph == m_per / 2) m_w = 0;
                if (m_ph < 65535) m_ph++;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            check(lrck_master ? "R4 wclk" : "R3 wclk", wclk_out, lrck_master ? lrck_in : m_w);
            check(m_fr < 0 ? "R2 c_out" : "R5 c_out", c_out, m_c);
            check(m_fr < 0 ? "R2 u_out" : "R5 u_out", u_out, m_u);
            check(m_fr < 0 ? "R2 blk" : (m_fr <= 2 ? "R6 blk" : "R7 blk"),
                  blk_ind, (m_fr >= 2 && m_fr < 18));
        end
    end

    task automatic frame(input int p, input bit z, input bit restart_chk);
        for (int i = 0; i < p; i++) begin
            @(posedge clk); #1;
            if (i == 1 && restart_chk) check("R8 restart", blk_ind, 1'b0);
            frame_stb = (i == 0);
            z_flag    = z && (i == 0);
            if (i == 0) begin
                lf   = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                c_in = lf[0];
                u_in = lf[3];
            end
            lrck_in = lrck_master ? (((i + 3) % p) < (p / 2)) : 1'b0;
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1;
        check("R1 blk", blk_ind, 1'b0);
        check("R1 c_out", c_out, 1'b0);
        check("R1 u_out", u_out, 1'b0);
        check("R1 wclk", wclk_out, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 blk after release", blk_ind, 1'b0);
        check("R1 c_out after release", c_out, 1'b0);
        // R2: frames before any block start
        for (int k = 0; k < 5; k++) frame(8, 1'b0, 1'b0);
        // R6 R7: full pulse, even period
        frame(8, 1'b1, 1'b0);
        for (int k = 0; k < 25; k++) frame(8, 1'b0, 1'b0);
        // R8: early block start while indicator high, period changes
        frame(10, 1'b1, 1'b0);
        for (int k = 0; k < 8; k++) frame(10, 1'b0, 1'b0);
        check("R8 high before restart", blk_ind, 1'b1);
        frame(10, 1'b1, 1'b1);
        for (int k = 0; k < 24; k++) frame(10, 1'b0, 1'b0);
        // R3: odd period
        frame(7, 1'b1, 1'b0);
        for (int k = 0; k < 20; k++) frame(7, 1'b0, 1'b0);
        // R4 R5: master mode with offset left/right clock
        lrck_master = 1'b1;
        frame(12, 1'b1, 1'b0);
        for (int k = 0; k < 25; k++) frame(12, 1'b0, 1'b0);
        frame_stb = 1'b0; z_flag = 1'b0;
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule